// File: doc/BRIEF.md
# Dual-Rail Power-Up Enable Sequencer

This clocked controller decides when each of two switching regulators, rail A and rail B, may start. Each rail has a three-level enable input. The low, float and high levels are resolved outside the block and arrive here as 2-bit codes.

A rail whose code is high starts on its own. A rail whose code is float starts only when the other rail's code is high. It then waits until that other rail is enabled and reports that it is in regulation. No rail starts while the shared supply is below its power-on-reset level. Once a rail is enabled, a soft-start window is timed for it, and a power-good delay is counted from its enable.

The block also raises a request for the shared supply whenever any of the three enables is high, including a third, plain auxiliary enable. It drives an open-drain power-good control that is released only when every wanted rail has run its full delay. A fault input pulls that control low in the same cycle. The regulation loops, comparators and supply regulator stay outside the block and report in as plain digital levels.

There is no data stream here. Every pin is a plain control or status level with no valid/ready handshake and no back-pressure. Timings are set by a clock-rate parameter. At the default 1 MHz the soft-start window is 1500 cycles and the power-good delay is 2750 cycles, and a bench may override the rate to shorten both.

Top module: `dual_rail_seq`

## Requirements
- R1: Enable codes are 2'b00 low, 2'b01 high, 2'b10 float; the reserved code 2'b11 behaves exactly as low.
- R2: With `supply_ok` high, a rail whose code is high enables on the next clock edge. A rail whose code is low stays off. A float rail whose partner is low or float stays off.
- R3: When both codes are high, both rails enable on the same clock edge.
- R4: A float rail whose partner is high waits. It enables on the clock edge after a cycle in which the partner is enabled and its regulation input is high.
- R5: `supply_req` is high in the same cycle whenever any rail code is high or `aux_en` is high, independent of `supply_ok`.
- R6: No rail enables while `supply_ok` is low. If `supply_ok` falls, both rails disable on the next edge and their timers restart from zero on the next enable.
- R7: A rail's soft-start output is high for exactly SS_CYC = CLK_KHZ*SS_US/1000 cycles, starting in the cycle its enable rises.
- R8: `pg_od_n` is high (released) only when at least one rail is wanted and every wanted rail has been enabled for PG_CYC = CLK_KHZ*PG_US/1000 cycles. It is low after reset and whenever no rail is wanted. A waiting dependent rail counts as wanted.
- R9: `fault` high forces `pg_od_n` low in the same cycle, and releasing `fault` restores it in the same cycle.
- R10: When a rail's code stops requesting it, the rail disables on the next edge. A later re-enable retimes soft-start and power-good from the new enable.
- R11: `supply_ok` low forces `pg_od_n` low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_a_code | input | 2 | Rail A enable level code |
| en_b_code | input | 2 | Rail B enable level code |
| aux_en | input | 1 | Auxiliary enable that only requests the supply |
| supply_ok | input | 1 | Shared supply is above its power-on-reset level |
| fault | input | 1 | Any detected fault |
| rail_a_inreg | input | 1 | Rail A reports its output in regulation |
| rail_b_inreg | input | 1 | Rail B reports its output in regulation |
| supply_req | output | 1 | Request to start the shared supply |
| rail_a_en | output | 1 | Rail A enable |
| rail_b_en | output | 1 | Rail B enable |
| rail_a_ss | output | 1 | Rail A soft-start window active |
| rail_b_ss | output | 1 | Rail B soft-start window active |
| pg_od_n | output | 1 | Power-good control; 0 turns the pull-down on |

## Verification
Loss of the shared supply and a running rail meet in the same cycle. When `supply_ok` drops while a rail is enabled, the power-good control must fall at once, while the rail enable must fall only at the following edge. The bench provokes this after a rail has reached power-good and checks the full output vector in both cycles against a queue of expected values. A similar collision is driven when a fault pulse lands while power-good is released, and when a regulation report arrives for a dependent start while the partner rail is already good.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int NRAIL = 2;

  typedef enum logic [1:0] {
    EN_LOW   = 2'b00,
    EN_HIGH  = 2'b01,
    EN_FLOAT = 2'b10,
    EN_RSVD  = 2'b11
  } en_code_t;

  typedef enum logic [1:0] {
    RM_OFF   = 2'd0,
    RM_NOW   = 2'd1,
    RM_AFTER = 2'd2
  } rail_mode_t;

  // R1/R2/R4: a rail runs alone when high, follows a high partner when float
  function automatic rail_mode_t rail_mode(input logic [1:0] mine,
                                           input logic [1:0] other);
    if (mine == EN_HIGH) return RM_NOW;
    if (mine == EN_FLOAT && other == EN_HIGH) return RM_AFTER;
    return RM_OFF;
  endfunction

endpackage

// File: rtl/seq_en_decode.sv
module seq_en_decode
  import seq_pkg::*;
(
  input  logic [NRAIL-1:0][1:0] codes,
  input  logic                  aux_en,
  output rail_mode_t            mode [NRAIL],
  output logic                  supply_req
);

  logic [NRAIL-1:0] high_v;

  for (genvar i = 0; i < NRAIL; i++) begin : g_dec
    localparam int OI = NRAIL - 1 - i;
    assign mode[i]   = rail_mode(codes[i], codes[OI]);
    assign high_v[i] = (codes[i] == EN_HIGH);
  end

  // R5: supply request from any high enable
  assign supply_req = aux_en | (|high_v);

endmodule

// File: rtl/seq_rail_ctrl.sv
module seq_rail_ctrl
  import seq_pkg::*;
#(
  parameter int SS_CYC = 1500,
  parameter int PG_CYC = 2750
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  rail_mode_t mode,
  input  logic       other_en,
  input  logic       other_inreg,
  output logic       en,
  output logic       ss,
  output logic       pg_done
);

  localparam int CW = $clog2(PG_CYC + 1);
  localparam logic [CW-1:0] SS_L = CW'(SS_CYC);
  localparam logic [CW-1:0] PG_L = CW'(PG_CYC);

  logic          en_q;
  logic [CW-1:0] cnt_q;
  logic          start_ok;

  // R4: dependent start needs the partner running and in regulation
  assign start_ok = (mode == RM_NOW) ||
                    (mode == RM_AFTER && other_en && other_inreg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (!supply_ok || mode == RM_OFF) begin
      en_q  <= 1'b0;                       // R6, R10
      cnt_q <= '0;
    end else if (!en_q) begin
      en_q  <= start_ok;
      cnt_q <= '0;
    end else if (cnt_q != PG_L) begin
      cnt_q <= cnt_q + 1'b1;               // saturates at PG_L
    end
  end

  assign en      = en_q;
  assign ss      = en_q && (cnt_q < SS_L);   // R7
  assign pg_done = en_q && (cnt_q == PG_L);  // R8

endmodule

// File: rtl/seq_pg_combine.sv
module seq_pg_combine #(
  parameter int N = 2
) (
  input  logic         supply_ok,
  input  logic         fault,
  input  logic [N-1:0] want,
  input  logic [N-1:0] done,
  output logic         pg_od_n
);

  logic all_done;

  assign all_done = &(~want | done);

  // R8, R9, R11: release only when all wanted rails are done, no fault, supply up
  assign pg_od_n = supply_ok & ~fault & (|want) & all_done;

endmodule

// File: rtl/dual_rail_seq.sv
module dual_rail_seq
  import seq_pkg::*;
#(
  parameter int CLK_KHZ = 1000,
  parameter int SS_US   = 1500,
  parameter int PG_US   = 2750
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] en_a_code,
  input  logic [1:0] en_b_code,
  input  logic       aux_en,
  input  logic       supply_ok,
  input  logic       fault,
  input  logic       rail_a_inreg,
  input  logic       rail_b_inreg,
  output logic       supply_req,
  output logic       rail_a_en,
  output logic       rail_b_en,
  output logic       rail_a_ss,
  output logic       rail_b_ss,
  output logic       pg_od_n
);

  localparam int SS_CYC = CLK_KHZ * SS_US / 1000;
  localparam int PG_CYC = CLK_KHZ * PG_US / 1000;

  logic [NRAIL-1:0][1:0] codes;
  rail_mode_t            mode [NRAIL];
  logic [NRAIL-1:0]      inreg_v, en_v, ss_v, done_v, want_v;

  assign codes   = {en_b_code, en_a_code};
  assign inreg_v = {rail_b_inreg, rail_a_inreg};

  seq_en_decode u_dec (
    .codes      (codes),
    .aux_en     (aux_en),
    .mode       (mode),
    .supply_req (supply_req)
  );

  for (genvar i = 0; i < NRAIL; i++) begin : g_rail
    localparam int OI = NRAIL - 1 - i;

    seq_rail_ctrl #(
      .SS_CYC (SS_CYC),
      .PG_CYC (PG_CYC)
    ) u_rail (
      .clk         (clk),
      .rst_n       (rst_n),
      .supply_ok   (supply_ok),
      .mode        (mode[i]),
      .other_en    (en_v[OI]),
      .other_inreg (inreg_v[OI]),
      .en          (en_v[i]),
      .ss          (ss_v[i]),
      .pg_done     (done_v[i])
    );

    assign want_v[i] = (mode[i] != RM_OFF);
  end

  seq_pg_combine #(.N(NRAIL)) u_pg (
    .supply_ok (supply_ok),
    .fault     (fault),
    .want      (want_v),
    .done      (done_v),
    .pg_od_n   (pg_od_n)
  );

  assign rail_a_en = en_v[0];
  assign rail_b_en = en_v[1];
  assign rail_a_ss = ss_v[0];
  assign rail_b_ss = ss_v[1];

endmodule

// File: rtl/seq_checker.sv
module seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] en_a_code,
  input logic [1:0] en_b_code,
  input logic       supply_ok,
  input logic       fault,
  input logic       rail_a_inreg,
  input logic       rail_b_inreg,
  input logic       rail_a_en,
  input logic       rail_b_en,
  input logic       rail_a_ss,
  input logic       rail_b_ss,
  input logic       pg_od_n
);

  p_low_code_off_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a_code == 2'b00 || en_a_code == 2'b11) |=> !rail_a_en);

  p_low_code_off_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_b_code == 2'b00 || en_b_code == 2'b11) |=> !rail_b_en);

  p_both_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a_code == 2'b01 && en_b_code == 2'b01 && supply_ok &&
     !rail_a_en && !rail_b_en) |=> (rail_a_en && rail_b_en));

  p_dep_b_after_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rail_b_en) && $past(en_b_code) == 2'b10) |->
      ($past(rail_a_en) && $past(rail_a_inreg)));

  p_dep_a_after_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rail_a_en) && $past(en_a_code) == 2'b10) |->
      ($past(rail_b_en) && $past(rail_b_inreg)));

  p_start_gated_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_a_en) |-> $past(supply_ok));

  p_supply_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!rail_a_en && !rail_b_en));

  p_ss_on_start_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_a_en) |-> rail_a_ss);

  p_ss_on_start_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_b_en) |-> rail_b_ss);

  p_pg_needs_rail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pg_od_n |-> (rail_a_en || rail_b_en));

  p_fault_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !pg_od_n);

  p_pg_supply_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> !pg_od_n);

endmodule

bind dual_rail_seq seq_checker u_seq_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .en_a_code    (en_a_code),
  .en_b_code    (en_b_code),
  .supply_ok    (supply_ok),
  .fault        (fault),
  .rail_a_inreg (rail_a_inreg),
  .rail_b_inreg (rail_b_inreg),
  .rail_a_en    (rail_a_en),
  .rail_b_en    (rail_b_en),
  .rail_a_ss    (rail_a_ss),
  .rail_b_ss    (rail_b_ss),
  .pg_od_n      (pg_od_n)
);

// File: tb/tb_dual_rail_seq.sv
module tb_dual_rail_seq;

  localparam int CLK_KHZ = 10;
  localparam int SS_CYC  = CLK_KHZ * 1500 / 1000;
  localparam int PG_CYC  = CLK_KHZ * 2750 / 1000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] en_a_code, en_b_code;
  logic       aux_en, supply_ok, fault, rail_a_inreg, rail_b_inreg;
  logic       supply_req, rail_a_en, rail_b_en, rail_a_ss, rail_b_ss, pg_od_n;

  always #5 clk = ~clk;

  dual_rail_seq #(.CLK_KHZ(CLK_KHZ)) dut (
    .clk(clk), .rst_n(rst_n), .en_a_code(en_a_code), .en_b_code(en_b_code),
    .aux_en(aux_en), .supply_ok(supply_ok), .fault(fault),
    .rail_a_inreg(rail_a_inreg), .rail_b_inreg(rail_b_inreg),
    .supply_req(supply_req), .rail_a_en(rail_a_en), .rail_b_en(rail_b_en),
    .rail_a_ss(rail_a_ss), .rail_b_ss(rail_b_ss), .pg_od_n(pg_od_n)
  );

  int cyc = 0;
  int ntest = 0;
  int nfail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard: {supply_req, a_en, b_en, a_ss, b_ss, pg_od_n}
  int         q_t[$];
  logic [5:0] q_v[$];
  string      q_g[$];

  task automatic chk(input int t, input logic [5:0] v, input string tag);
    q_t.push_back(t);
    q_v.push_back(v);
    q_g.push_back(tag);
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) begin
      @(posedge clk);
      #2;
    end
  endtask

  always @(negedge clk) begin
    logic [5:0] obs;
    obs = {supply_req, rail_a_en, rail_b_en, rail_a_ss, rail_b_ss, pg_od_n};
    while (q_t.size() > 0 && q_t[0] <= cyc) begin
      ntest++;
      if (q_t[0] != cyc) begin
        nfail++;
        $display("FAIL %s: check for cycle %0d missed, actual %b expected %b",
                 q_g[0], q_t[0], obs, q_v[0]);
      end else if (obs !== q_v[0]) begin
        nfail++;
        $display("FAIL %s at cycle %0d: actual %b expected %b",
                 q_g[0], cyc, obs, q_v[0]);
      end
      void'(q_t.pop_front());
      void'(q_v.pop_front());
      void'(q_g.pop_front());
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    ntest++;
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    int b, m, p, q, r, s, t, u, w, x, z, k, n, g;
    rst_n = 1'b0; en_a_code = 2'b00; en_b_code = 2'b00; aux_en = 1'b0;
    supply_ok = 1'b0; fault = 1'b0; rail_a_inreg = 1'b0; rail_b_inreg = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    chk(cyc, 6'b000000, "R8 reset");

    // single rail, gating by supply, timing, fault, supply loss
    wait_cyc(cyc + 2); b = cyc;
    en_a_code = 2'b01;
    chk(b, 6'b100000, "R5");
    chk(b + 3, 6'b100000, "R6 no start");
    wait_cyc(b + 3); m = cyc;
    supply_ok = 1'b1;
    chk(m + 1, 6'b110100, "R2");
    chk(m + SS_CYC, 6'b110100, "R7 ss last");
    chk(m + SS_CYC + 1, 6'b110000, "R7 ss end");
    chk(m + PG_CYC, 6'b110000, "R8 pg early");
    chk(m + PG_CYC + 1, 6'b110001, "R8 pg");
    wait_cyc(m + PG_CYC + 3); p = cyc;
    fault = 1'b1;
    chk(p, 6'b110000, "R9 fault");
    wait_cyc(p + 1);
    fault = 1'b0;
    chk(p + 1, 6'b110001, "R9 release");
    wait_cyc(p + 3); q = cyc;
    supply_ok = 1'b0;
    chk(q, 6'b110000, "R11");
    chk(q + 1, 6'b100000, "R6 loss");
    wait_cyc(q + 2); r = cyc;
    supply_ok = 1'b1;
    chk(r + 1, 6'b110100, "R6 restart");
    wait_cyc(r + 5); s = cyc;
    en_a_code = 2'b00;
    chk(s, 6'b010100, "R10 pending");
    chk(s + 1, 6'b000000, "R10 off");
    wait_cyc(s + 3); t = cyc;
    en_a_code = 2'b11;
    chk(t + 1, 6'b000000, "R1 reserved");
    wait_cyc(t + 3);
    en_b_code = 2'b10;
    chk(t + 5, 6'b000000, "R1 reserved vs float");
    wait_cyc(t + 6);
    en_a_code = 2'b00; en_b_code = 2'b00;

    // both high
    wait_cyc(cyc + 2); u = cyc;
    en_a_code = 2'b01; en_b_code = 2'b01;
    chk(u, 6'b100000, "R3 before");
    chk(u + 1, 6'b111110, "R3 together");
    chk(u + PG_CYC, 6'b111000, "R8 both early");
    chk(u + PG_CYC + 1, 6'b111001, "R8 both");
    wait_cyc(u + PG_CYC + 3);
    en_a_code = 2'b00; en_b_code = 2'b00;
    chk(cyc + 1, 6'b000000, "R10 both off");

    // A high, B float: B follows A regulation
    wait_cyc(cyc + 3); w = cyc;
    en_a_code = 2'b01; en_b_code = 2'b10;
    chk(w + 1, 6'b110100, "R2 leader");
    chk(w + 5, 6'b110100, "R4 waiting");
    chk(w + PG_CYC + 3, 6'b110000, "R8 waiting rail");
    wait_cyc(w + PG_CYC + 4); x = cyc;
    rail_a_inreg = 1'b1;
    chk(x, 6'b110000, "R4 not yet");
    chk(x + 1, 6'b111010, "R4 follower");
    chk(x + PG_CYC, 6'b111000, "R8 follower early");
    chk(x + PG_CYC + 1, 6'b111001, "R8 follower");
    wait_cyc(x + PG_CYC + 3);
    en_a_code = 2'b00; en_b_code = 2'b00; rail_a_inreg = 1'b0;
    chk(cyc + 1, 6'b000000, "R10 clear");

    // B high, A float: A follows B regulation
    wait_cyc(cyc + 3); z = cyc;
    en_a_code = 2'b10; en_b_code = 2'b01;
    chk(z + 1, 6'b101010, "R4 B leads");
    wait_cyc(z + 4);
    rail_b_inreg = 1'b1;
    chk(z + 5, 6'b111110, "R4 A follows");
    wait_cyc(z + 8);
    en_a_code = 2'b00; en_b_code = 2'b00; rail_b_inreg = 1'b0;
    chk(z + 9, 6'b000000, "R10 clear");

    // float with low or float partner
    wait_cyc(cyc + 2); k = cyc;
    en_a_code = 2'b10; en_b_code = 2'b00;
    chk(k + 2, 6'b000000, "R2 float low");
    wait_cyc(k + 3);
    en_b_code = 2'b10;
    chk(k + 5, 6'b000000, "R2 float float");
    wait_cyc(k + 6);
    en_a_code = 2'b00; en_b_code = 2'b01;
    chk(k + 7, 6'b101010, "R2 B alone");
    wait_cyc(k + 9);
    en_b_code = 2'b00;
    chk(k + 10, 6'b000000, "R10 B off");

    // auxiliary enable only requests supply
    wait_cyc(cyc + 2); n = cyc;
    aux_en = 1'b1;
    chk(n, 6'b100000, "R5 aux");
    chk(n + 2, 6'b100000, "R5 aux hold");
    wait_cyc(n + 3);
    aux_en = 1'b0;
    chk(n + 3, 6'b000000, "R5 aux off");

    // drop and re-enable retimes
    wait_cyc(cyc + 2); g = cyc;
    en_a_code = 2'b01;
    chk(g + 1, 6'b110100, "R2");
    wait_cyc(g + 5);
    en_a_code = 2'b00;
    wait_cyc(g + 6);
    en_a_code = 2'b01;
    chk(g + 6, 6'b100000, "R10 dropped");
    chk(g + 7, 6'b110100, "R10 restart");
    chk(g + 6 + SS_CYC, 6'b110100, "R10 ss last");
    chk(g + 7 + SS_CYC, 6'b110000, "R10 ss end");
    chk(g + 6 + PG_CYC, 6'b110000, "R10 pg early");
    chk(g + 7 + PG_CYC, 6'b110001, "R10 pg");

    while (q_t.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

endmodule